// File: doc/BRIEF.md
# Seeded Stochastic Rounding Narrow-Float Converter

This block sits at the output of an arithmetic datapath and narrows a stream of FP32 words to one of two 8-bit floating-point formats. Each word arrives with a 4-bit type tag. Tag 0 selects a format with 4 exponent bits and 3 mantissa bits and no infinity encoding. Tag 1 selects a format with 5 exponent bits and 2 mantissa bits that does encode infinity. Any other tag passes the FP32 word through unchanged. The stream uses a valid/ready handshake and passes through one register stage.

Rounding is set by one global mode bit. With the bit clear, the block rounds to nearest with ties to even. With the bit set, it rounds stochastically. In that mode, the low bits of a per-format pseudo-random generator are added to the discarded mantissa bits, and the carry decides whether to round up. Software seeds a generator with a single write-only word. That word names the format slot and supplies the new 21-bit state, so one write both picks and reseeds a generator. A signed 6-bit bias adjust moves the exponent bias of both narrow formats.

Top module: `sr_narrow_conv`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, the mode and bias fields read 0, and both generators hold the constant 21'h0ACE1.
- R2: The configuration port decodes cfg_addr as follows: 0 is the seed word, 1 is the mode bit in wdata[0], and 2 is the bias in wdata[5:0]. Reads of address 0 (and 3) return zero. Mode and bias read back the last value written.
- R3: With mode 0, the kept mantissa rounds up when the discarded bits exceed one half, or equal one half and the kept LSB is 1. A mantissa carry increments the exponent.
- R4: With mode 1, the kept mantissa rounds up exactly when the discarded bits plus the same number of low bits of the slot's generator carry out of that width. The width is 20 bits for tag 0 and 21 bits for tag 1.
- R5: A write to address 0 with wdata[31:28] < 2 loads slot wdata[31:28] with wdata[20:0]. A seed value of zero loads 21'h0ACE1 instead. Writes naming any other slot change no generator.
- R6: A generator steps once for each accepted word of its own tag, in either mode. A step shifts the state left and feeds bit20 XOR bit18 into bit 0. The current state rounds the word, and the step happens afterwards.
- R7: Words with a tag of 2 or above come out with the same 32 bits and the same tag.
- R8: A NaN input gives 0x7F for tag 0 and 0x7E for tag 1, regardless of its sign.
- R9: Overflow and infinity inputs depend on the mode. With mode 1 they saturate to sign|0x7E (tag 0) or sign|0x7B (tag 1). With mode 0 they give sign|0x7F (tag 0) or sign|0x7C (tag 1). For tag 0, exponent 15 with mantissa 7 counts as overflow.
- R10: The narrow exponent is the FP32 exponent − 127 + nominal bias (7 or 15) + the signed bias field + any round carry. A result of 0 or below, or an FP32 exponent field of 0, gives a signed zero. Narrow results are placed in out_data[7:0] with the upper bits zero.
- R11: in_ready equals !out_valid || out_ready. A word is accepted when in_valid && in_ready and appears on the next cycle. While out_valid && !out_ready, out_data and out_tag hold.
- R12: When a seed write and an accepted word of the same slot fall in one cycle, the word rounds with the old state and the slot then holds the new seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | FP32 input word |
| in_tag | input | 4 | Output type tag |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | 32 | Converted word |
| out_tag | output | 4 | Tag of the converted word |

## Verification
The hardest case to reach from the ports is a seed write to a slot landing in the very cycle that slot consumes a word. That case needs a write strobe and an accepted transfer aligned to the same edge. The bench drives both together with the pipeline empty. It then sends a second word of that tag, whose stochastic result shows whether the seed or the stepped state survived. Long runs under random backpressure, interleaved tags and occasional reseeds check that each generator steps only on its own accepted words. These runs use a behavioural model of both generators and of the rounding.

// File: rtl/sr_conv_pkg.sv
package sr_conv_pkg;
  localparam int unsigned SEED_W    = 21;
  localparam int unsigned TAG_W     = 4;
  localparam int unsigned NUM_SLOTS = 2;
  localparam int unsigned NARROW_W  = 8;
  localparam int unsigned SLOT_LSB  = 28;
  localparam logic [SEED_W-1:0] SEED_FALLBACK = 21'h0ACE1;

  typedef enum logic [1:0] {
    CFG_SEED = 2'd0,
    CFG_MODE = 2'd1,
    CFG_BIAS = 2'd2,
    CFG_NONE = 2'd3
  } cfg_addr_e;
endpackage

// File: rtl/sr_lfsr_bank.sv
module sr_lfsr_bank #(
  parameter int unsigned SLOTS  = 2,
  parameter int unsigned W      = 21,
  parameter int unsigned SW     = 4,
  parameter int unsigned TAP_HI = 20,
  parameter int unsigned TAP_LO = 18,
  parameter logic [W-1:0] FALLBACK = '1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    seed_we,
  input  logic [SW-1:0]           seed_slot,
  input  logic [W-1:0]            seed_val,
  input  logic                    adv_en,
  input  logic [SW-1:0]           adv_slot,
  output logic [SLOTS-1:0][W-1:0] state_o
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [W-1:0] st_q, st_d;
    logic         hit_seed, hit_adv, st_en;

    always_comb begin
      hit_seed = seed_we && (seed_slot == SW'(g));
      hit_adv  = adv_en  && (adv_slot  == SW'(g));
      st_en    = hit_seed || hit_adv;
      if (hit_seed) begin
        st_d = (seed_val == '0) ? FALLBACK : seed_val;
      end else begin
        st_d = {st_q[W-2:0], st_q[TAP_HI] ^ st_q[TAP_LO]};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q <= FALLBACK;
      else if (st_en) st_q <= st_d;
    end

    assign state_o[g] = st_q;
  end
endmodule

// File: rtl/sr_fp_narrow.sv
module sr_fp_narrow #(
  parameter int unsigned EW      = 4,
  parameter int unsigned MW      = 3,
  parameter bit          HAS_INF = 1'b0,
  parameter int unsigned RW      = 21
) (
  input  logic [31:0]       f32_i,
  input  logic              stoch_i,
  input  logic [5:0]        bias_i,
  input  logic [RW-1:0]     rnd_i,
  output logic [EW+MW:0]    out_o
);
  localparam int unsigned DROP = 23 - MW;
  localparam int unsigned NOM  = (2 ** (EW - 1)) - 1;
  localparam int unsigned EMAX = HAS_INF ? (2 ** EW) - 2 : (2 ** EW) - 1;
  localparam logic signed [10:0] EMAX_S = 11'(EMAX);
  localparam logic [DROP-1:0] HALF = {1'b1, {(DROP-1){1'b0}}};
  localparam logic [EW+MW-1:0] NAN_MAG = HAS_INF ?
      {{EW{1'b1}}, 1'b1, {(MW-1){1'b0}}} : {(EW+MW){1'b1}};
  localparam logic [EW+MW-1:0] MAX_MAG = HAS_INF ?
      {{(EW-1){1'b1}}, 1'b0, {MW{1'b1}}} : {{EW{1'b1}}, {(MW-1){1'b1}}, 1'b0};
  localparam logic [EW+MW-1:0] OVF_MAG = HAS_INF ?
      {{EW{1'b1}}, {MW{1'b0}}} : NAN_MAG;

  logic            sgn;
  logic [7:0]      exp_f;
  logic [22:0]     man_f;
  logic [MW-1:0]   keep, fmant;
  logic [DROP-1:0] rest;
  logic [DROP:0]   ssum;
  logic [MW:0]     rmant;
  logic            rne_up, up, is_nan, is_inf, ovf, unf;
  logic [10:0]     e_adj;
  logic            unused_rnd;

  assign unused_rnd = ^rnd_i;

  always_comb begin
    sgn    = f32_i[31];
    exp_f  = f32_i[30:23];
    man_f  = f32_i[22:0];
    keep   = man_f[22 -: MW];
    rest   = man_f[DROP-1:0];
    ssum   = {1'b0, rest} + {1'b0, rnd_i[DROP-1:0]};
    rne_up = (rest > HALF) || ((rest == HALF) && keep[0]);
    up     = stoch_i ? ssum[DROP] : rne_up;
    rmant  = {1'b0, keep} + {{MW{1'b0}}, up};
    fmant  = rmant[MW] ? '0 : rmant[MW-1:0];
    e_adj  = {3'b000, exp_f} - 11'd127 + 11'(NOM)
           + {{5{bias_i[5]}}, bias_i} + {10'd0, rmant[MW]};
    is_nan = (exp_f == 8'hFF) && (man_f != '0);
    is_inf = (exp_f == 8'hFF) && (man_f == '0);
    ovf    = is_inf || ($signed(e_adj) > EMAX_S)
           || (!HAS_INF && ($signed(e_adj) == EMAX_S) && (fmant == '1));
    unf    = (exp_f == 8'h00) || ($signed(e_adj) < 11'sd1);

    if (is_nan)      out_o = {1'b0, NAN_MAG};
    else if (ovf)    out_o = {sgn, stoch_i ? MAX_MAG : OVF_MAG};
    else if (unf)    out_o = {sgn, {(EW+MW){1'b0}}};
    else             out_o = {sgn, e_adj[EW-1:0], fmant};
  end
endmodule

// File: rtl/sr_narrow_conv.sv
module sr_narrow_conv
  import sr_conv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [1:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  output logic [TAG_W-1:0] out_tag
);
  localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  cfg_addr_e addr_sel;
  logic      mode_q, mode_en;
  logic [5:0] bias_q;
  logic      bias_en, seed_we, accept;
  logic      ov_q, ov_d;
  logic [31:0] od_q, od_d;
  logic [TAG_W-1:0] ot_q;
  logic [NUM_SLOTS-1:0][SEED_W-1:0] gen_state;
  logic [NUM_SLOTS-1:0][NARROW_W-1:0] narrow;
  logic      unused_wdata;

  assign unused_wdata = ^cfg_wdata[SLOT_LSB-1:SEED_W];

  // configuration decode
  always_comb begin
    addr_sel = cfg_addr_e'(cfg_addr);
    mode_en  = cfg_wr_en && (addr_sel == CFG_MODE);
    bias_en  = cfg_wr_en && (addr_sel == CFG_BIAS);
    seed_we  = cfg_wr_en && (addr_sel == CFG_SEED);
    case (addr_sel)
      CFG_MODE: cfg_rdata = {31'd0, mode_q};
      CFG_BIAS: cfg_rdata = {26'd0, bias_q};
      default:  cfg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (mode_en) mode_q <= cfg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bias_q <= 6'd0;
    else if (bias_en) bias_q <= cfg_wdata[5:0];
  end

  assign in_ready = !ov_q || out_ready;
  assign accept   = in_valid && in_ready;

  sr_lfsr_bank #(
    .SLOTS   (NUM_SLOTS),
    .W       (SEED_W),
    .SW      (TAG_W),
    .TAP_HI  (20),
    .TAP_LO  (18),
    .FALLBACK(SEED_FALLBACK)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed_we  (seed_we),
    .seed_slot(cfg_wdata[31:SLOT_LSB]),
    .seed_val (cfg_wdata[SEED_W-1:0]),
    .adv_en   (accept),
    .adv_slot (in_tag),
    .state_o  (gen_state)
  );

  // one converter per narrow format; the slot index picks the variant
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cvt
    sr_fp_narrow #(
      .EW     ((g == 0) ? 4 : 5),
      .MW     ((g == 0) ? 3 : 2),
      .HAS_INF(g != 0),
      .RW     (SEED_W)
    ) u_cvt (
      .f32_i  (in_data),
      .stoch_i(mode_q),
      .bias_i (bias_q),
      .rnd_i  (gen_state[g]),
      .out_o  (narrow[g])
    );
  end

  // output stage next state
  always_comb begin
    if (in_tag < TAG_W'(NUM_SLOTS)) begin
      od_d = {{(32-NARROW_W){1'b0}}, narrow[in_tag[SLOT_W-1:0]]};
    end else begin
      od_d = in_data;
    end
    if (accept)         ov_d = 1'b1;
    else if (out_ready) ov_d = 1'b0;
    else                ov_d = ov_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ov_q <= 1'b0;
    else        ov_q <= ov_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_q <= 32'd0;
      ot_q <= '0;
    end else if (accept) begin
      od_q <= od_d;
      ot_q <= in_tag;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_tag   = ot_q;
endmodule

// File: rtl/sr_conv_checker.sv
module sr_conv_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr_en,
  input logic [1:0]  cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_data,
  input logic [3:0]  in_tag,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic [3:0]  out_tag
);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tag)));

  assert_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_mode_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_addr == 2'd1) |=>
      ((cfg_addr != 2'd1) || (cfg_rdata[0] == $past(cfg_wdata[0]))));

  assert_bias_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_addr == 2'd2) |=>
      ((cfg_addr != 2'd2) || (cfg_rdata[5:0] == $past(cfg_wdata[5:0]))));

  assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_tag >= 4'd2) |=>
      (out_data == $past(in_data) && out_tag == $past(in_tag)));

  assert_nan_e5_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_tag == 4'd1 && in_data[30:23] == 8'hFF && in_data[22:0] != 23'd0)
      |=> (out_data == 32'h7E));

  assert_nan_e4_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_tag == 4'd0 && in_data[30:23] == 8'hFF && in_data[22:0] != 23'd0)
      |=> (out_data == 32'h7F));
endmodule

bind sr_narrow_conv sr_conv_checker u_chk (.*);

// File: tb/sr_narrow_conv_bench.sv
module sr_narrow_conv_bench;
  logic        clk, rst_n;
  logic        cfg_wr_en;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        in_valid, in_ready;
  logic [31:0] in_data;
  logic [3:0]  in_tag;
  logic        out_valid, out_ready;
  logic [31:0] out_data;
  logic [3:0]  out_tag;

  sr_narrow_conv u_sr_narrow_conv (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int lf[2];
  int mode_m = 0, bias_m = 0;
  logic [31:0] exp_q[$];
  logic [3:0]  etag_q[$];
  string       req_q[$];
  string       cur_req = "R3";
  bit          last_acc, held_v, rd_pend, done;
  logic [31:0] held_d, rd_exp;
  string       rd_req;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic int lstep(int s);
    return ((s << 1) & 'h1FFFFF) | (((s >> 20) ^ (s >> 18)) & 1);
  endfunction

  function automatic logic [31:0] ref_conv(logic [31:0] w, int tag, int stoch, int bias, int rnd);
    int mw, nb, d, sg, ex, man, sig, low, half, up, e, emax, nanc, maxf, infc;
    if (tag > 1) return w;
    mw = (tag == 0) ? 3 : 2;
    nb = (tag == 0) ? 7 : 15;
    emax = (tag == 0) ? 15 : 30;
    nanc = (tag == 0) ? 'h7F : 'h7E;
    maxf = (tag == 0) ? 'h7E : 'h7B;
    infc = (tag == 0) ? 'h7F : 'h7C;
    d = 23 - mw;
    sg = w[31] ? 128 : 0;
    ex = int'(w[30:23]);
    man = int'(w[22:0]);
    if (ex == 255 && man != 0) return 32'(nanc);
    if (ex == 255) return 32'(sg + (stoch != 0 ? maxf : infc));
    sig = man >> d;
    low = man % (1 << d);
    half = 1 << (d - 1);
    if (stoch != 0) up = ((low + (rnd % (1 << d))) >= (1 << d)) ? 1 : 0;
    else up = (low > half || (low == half && (sig % 2) == 1)) ? 1 : 0;
    sig = sig + up;
    e = ex - 127 + nb + bias;
    if (sig == (1 << mw)) begin sig = 0; e = e + 1; end
    if (ex == 0 || e <= 0) return 32'(sg);
    if (e > emax || (tag == 0 && e == 15 && sig == 7)) return 32'(sg + (stoch != 0 ? maxf : infc));
    return 32'(sg + e * (1 << mw) + sig);
  endfunction

  // one clock of model bookkeeping; inputs are already set at the falling edge
  task automatic step();
    int slot, sd;
    #5;
    last_acc = in_valid && in_ready;
    chk(in_ready === (!out_valid || out_ready), "R11 ready", 32'(in_ready), 32'(!out_valid || out_ready));
    if (held_v) chk(out_valid && out_data == held_d, "R11 hold", out_data, held_d);
    held_v = out_valid && !out_ready;
    held_d = out_data;
    if (rd_pend) chk(cfg_rdata == rd_exp, rd_req, cfg_rdata, rd_exp);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected output", out_data, 32'hx);
      end else begin
        automatic logic [31:0] ev = exp_q.pop_front();
        automatic logic [3:0]  et = etag_q.pop_front();
        automatic string       rq = req_q.pop_front();
        chk(out_data == ev, rq, out_data, ev);
        chk(out_tag == et, {rq, " tag"}, 32'(out_tag), 32'(et));
      end
    end
    if (last_acc) begin
      slot = int'(in_tag);
      exp_q.push_back(ref_conv(in_data, slot, mode_m, bias_m, (slot < 2) ? lf[slot] : 0));
      etag_q.push_back(in_tag);
      req_q.push_back(cur_req);
      if (slot < 2) lf[slot] = lstep(lf[slot]);
    end
    if (cfg_wr_en) begin
      case (cfg_addr)
        2'd0: begin
          slot = int'(cfg_wdata[31:28]);
          sd = int'(cfg_wdata[20:0]);
          if (slot < 2) lf[slot] = (sd == 0) ? 'h0ACE1 : sd;
        end
        2'd1: mode_m = int'(cfg_wdata[0]);
        2'd2: bias_m = cfg_wdata[5] ? int'(cfg_wdata[5:0]) - 64 : int'(cfg_wdata[5:0]);
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic send(logic [31:0] d, logic [3:0] t, string r);
    cur_req = r;
    in_valid = 1'b1; in_data = d; in_tag = t;
    do step(); while (!last_acc);
    in_valid = 1'b0;
  endtask

  task automatic cfg_write(logic [1:0] a, logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_wr_en = 1'b0;
  endtask

  task automatic read_check(logic [1:0] a, logic [31:0] e, string r);
    cfg_addr = a; rd_exp = e; rd_req = r; rd_pend = 1'b1;
    step();
    rd_pend = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_addr = 2'd3; cfg_wdata = '0;
    in_valid = 1'b0; in_data = '0; in_tag = '0; out_ready = 1'b1;
    lf[0] = 'h0ACE1; lf[1] = 'h0ACE1;
    held_v = 1'b0; rd_pend = 1'b0; done = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    read_check(2'd1, 32'd0, "R1 mode reset");
    read_check(2'd2, 32'd0, "R1 bias reset");
    // R1: reset generator state seen through a stochastic result
    cfg_write(2'd1, 32'd1);
    send(32'h3F8FFFFF, 4'd0, "R1 reset seed e4");
    send(32'h3F9FFFFF, 4'd1, "R1 reset seed e5");
    cfg_write(2'd1, 32'd0);

    // R2 register access
    cfg_write(2'd2, 32'h0000_0025);
    read_check(2'd2, 32'h25, "R2 bias readback");
    cfg_write(2'd2, 32'd0);
    cfg_write(2'd0, 32'h1001_2345);
    read_check(2'd0, 32'd0, "R2 seed reads zero");
    read_check(2'd3, 32'd0, "R2 unused reads zero");
    cfg_write(2'd1, 32'hFFFF_FFFF);
    read_check(2'd1, 32'd1, "R2 mode readback");
    cfg_write(2'd1, 32'd0);

    // R3 round to nearest even
    send(32'h3F800000, 4'd0, "R3 exact e4");
    send(32'h3F880000, 4'd0, "R3 tie even down e4");
    send(32'h3F980000, 4'd0, "R3 tie odd up e4");
    send(32'h3F8C0000, 4'd0, "R3 above half e4");
    send(32'h3FF80000, 4'd0, "R3 carry to exponent e4");
    send(32'hC0500000, 4'd1, "R3 tie e5");
    send(32'h40700001, 4'd1, "R3 carry e5");
    send(32'h3DCCCCCD, 4'd1, "R3 fraction e5");

    // R4 stochastic
    cfg_write(2'd1, 32'd1);
    for (int i = 0; i < 12; i++) send(32'h3F800000 + 32'(i * 32'h0003_1111), 4'(i % 2), "R4 stochastic");

    // R5 seed loads, zero seed, ignored slot
    cfg_write(2'd0, 32'h0000_0000 | 32'h001F_FFFF);
    send(32'h3F800001, 4'd0, "R5 all-ones seed");
    cfg_write(2'd0, 32'h1000_0000);
    send(32'h3F900000, 4'd1, "R5 zero seed");
    cfg_write(2'd0, 32'h5012_3456);
    send(32'h3F8AAAAA, 4'd0, "R5 foreign slot ignored");
    send(32'h3F955555, 4'd1, "R5 foreign slot ignored");

    // R6 stepping only on own tag
    cfg_write(2'd0, 32'h0000_0001);
    send(32'h40000000, 4'd2, "R6 pass no step");
    send(32'h3F800000, 4'd1, "R6 other slot");
    for (int i = 0; i < 6; i++) send(32'h3F87FFFF, 4'd0, "R6 sequence");

    // R12 seed write coincides with a word of the same slot
    cfg_wr_en = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'h0015_5555;
    in_valid = 1'b1; in_data = 32'h3F8FFFFF; in_tag = 4'd0; cur_req = "R12 old state";
    step();
    chk(last_acc, "R12 accept", 32'(last_acc), 32'd1);
    cfg_wr_en = 1'b0; in_valid = 1'b0;
    send(32'h3F8FFFFF, 4'd0, "R12 new seed");
    send(32'h3F8FFFFF, 4'd0, "R12 next step");

    // R7 pass-through
    send(32'hDEADBEEF, 4'd2, "R7 pass");
    send(32'h7FC00001, 4'd15, "R7 pass nan");

    // R8 NaN
    send(32'h7FC00000, 4'd0, "R8 nan e4");
    send(32'hFF800001, 4'd1, "R8 nan e5");

    // R9 overflow in both modes
    send(32'h7F000000, 4'd0, "R9 sat e4");
    send(32'hFF800000, 4'd1, "R9 sat inf e5");
    send(32'h43F00000, 4'd0, "R9 e15m7 sat e4");
    cfg_write(2'd1, 32'd0);
    send(32'h7F000000, 4'd0, "R9 rne ovf e4");
    send(32'hC7700000, 4'd1, "R9 rne ovf e5");
    send(32'h7F800000, 4'd1, "R9 rne inf e5");
    send(32'h43E00000, 4'd0, "R9 max finite e4");

    // R10 bias adjust and flush
    send(32'h3A000000, 4'd0, "R10 underflow e4");
    send(32'h80000000, 4'd1, "R10 signed zero");
    send(32'h00400000, 4'd0, "R10 denormal flush");
    cfg_write(2'd2, 32'd5);
    send(32'h3F800000, 4'd0, "R10 bias +5 e4");
    send(32'h3A000000, 4'd1, "R10 bias +5 e5");
    cfg_write(2'd2, 32'h0000_002C);
    send(32'h41000000, 4'd1, "R10 bias -20 e5");
    send(32'h3F800000, 4'd0, "R10 bias -20 flush");
    cfg_write(2'd2, 32'd0);

    // R11 random stream with backpressure and reseeds
    for (int c = 0; c < 6000; c++) begin
      automatic int sel = int'($urandom % 8);
      automatic int ex;
      automatic int tg = int'($urandom % 6);
      case (sel)
        0: ex = 0;
        1: ex = 255;
        2: ex = 127 + 6 + int'($urandom % 12);
        default: ex = 127 - 10 + int'($urandom % 22);
      endcase
      in_valid  = ($urandom % 4) != 0;
      in_tag    = (tg < 2) ? 4'(tg) : ((tg < 5) ? 4'(tg % 2) : 4'd9);
      in_data   = {1'($urandom), 8'(ex), 23'($urandom)};
      out_ready = ($urandom % 3) != 0;
      cur_req   = "R11 stream R6";
      if (($urandom % 40) == 0) begin
        cfg_wr_en = 1'b1;
        cfg_addr  = 2'($urandom % 3);
        cfg_wdata = $urandom;
      end
      step();
      cfg_wr_en = 1'b0;
    end
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (4) step();
    chk(exp_q.size() == 0, "R11 drain", 32'(exp_q.size()), 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule